// File: doc/BRIEF.md
# Latch-Array Dual-Port Nibble Memory

This block is a small memory of 32 words of 4 bits. It has one write port and one read port. Every stored bit is a transparent latch. The read side has no clock: the output follows the read address through a combinational multiplexer. It can be gated to zero with an output enable.

The write side has two modes, chosen by a mode input. In edge mode, a front-end latch holds address, data and the write strobe while the clock is high. The memory latches open only during that high phase, so the pair acts as a write on the rising edge. In level mode, the clock selection is forced to a constant 1 on both stages. The selected word then follows the input data for as long as the active-low write strobe is held low.

A single-port option makes the write address also serve as the read address. A clear input wipes the whole array, and so does the synchronous reset.

Top module: `latch_nibble_ram`

## Requirements
- R1: The array holds 2^5 = 32 independent words of 4 bits, addressed by 5-bit write and read addresses; each of the 32 addresses selects its own word.
- R2: With output enable at 1, `rd_data` equals the word at the read address combinationally, with no clock edge needed after the address changes.
- R3: With `edge_mode` = 1, a word is written on the rising clock edge from the `wr_addr`, `wr_data` and `wr_en_n` (active low) present just before that edge. Input changes while the clock is high, and a strobe pulsed low and released entirely within a low phase, leave the array unchanged.
- R4: A word keeps its value when it is not addressed by the write address, or when `wr_en_n` is 1.
- R5: With `edge_mode` = 0, the addressed word follows `wr_data` for as long as `wr_en_n` is 0. A read of that address shows the new data at once (write-through). The word keeps the last value when `wr_en_n` returns to 1.
- R6: When `clr` is 1 at a rising edge, every word reads 0 from that edge on. The clear wins over a write captured at the same edge.
- R7: With `rd_en` at 0, `rd_data` is 0 regardless of the array contents.
- R8: With `single_port` at 1, reads use `wr_addr` and the value on `rd_addr` has no effect.
- R9: `rst` (active high, synchronous) clears every word to 0 at the rising edge where it is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for edge-mode writes and for the clear register |
| rst | input | 1 | Synchronous active-high reset, clears the array |
| edge_mode | input | 1 | 1: edge-triggered write, 0: level-sensitive write |
| single_port | input | 1 | 1: write address also addresses the read |
| clr | input | 1 | Synchronous clear of the whole array |
| wr_addr | input | 5 | Write address |
| wr_data | input | 4 | Write data |
| wr_en_n | input | 1 | Write strobe, active low |
| rd_addr | input | 5 | Read address |
| rd_en | input | 1 | Output enable; 0 forces the output to 0 |
| rd_data | output | 4 | Read data |

## Verification
The hardest case to reach is the edge-mode capture window. It means showing that data presented while the clock is high is ignored, and that a strobe pulse that lives only inside a low phase writes nothing. The stimulus places input changes at fixed offsets inside each phase: 1 ns after the falling edge, and 1 ns after the rising edge. It then reads the affected words back asynchronously before the next edge. A clear is also issued in the same cycle as a pending write, to show that the clear wins.

// File: rtl/latch_nibble_pkg.sv
package latch_nibble_pkg;
  typedef enum logic {
    WR_LEVEL = 1'b0,
    WR_EDGE  = 1'b1
  } wr_mode_e;
endpackage

// File: rtl/lnr_front.sv
module lnr_front #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 4
) (
  input  logic              open_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              we_n_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              we_n_o
);
  always_latch begin
    if (open_i) begin
      addr_o <= addr_i;
      data_o <= data_i;
      we_n_o <= we_n_i;
    end
  end
endmodule

// File: rtl/lnr_word.sv
module lnr_word #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 4,
  parameter int IDX    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              edge_mode,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] f_addr_i,
  input  logic              f_we_n_i,
  input  logic [DATA_W-1:0] f_data_i,
  output logic [DATA_W-1:0] q_o
);
  logic sel;
  assign sel = (f_addr_i == ADDR_W'(IDX)) && !f_we_n_i;

  always_latch begin
    if (clr_i) q_o <= '0;
    else if (load_i && sel) q_o <= f_data_i;
  end

  // R3: edge-mode write lands the captured data
  assert_edge_write_R3: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && $past(edge_mode) && $past(sel) && !clr_i) |-> (q_o == $past(f_data_i)));

  // R4: no write intent at the edge, no change
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && $past(edge_mode) && !$past(sel) && !clr_i) |-> $stable(q_o));
endmodule

// File: rtl/lnr_read.sv
module lnr_read #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              single_port,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] words_i [DEPTH],
  output logic [DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] eff_addr;
  assign eff_addr = single_port ? wr_addr : rd_addr;

  always_comb begin
    rd_data = '0;
    if (rd_en) rd_data = words_i[eff_addr];
  end
endmodule

// File: rtl/latch_nibble_ram.sv
module latch_nibble_ram
  import latch_nibble_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              edge_mode,
  input  logic              single_port,
  input  logic              clr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  wr_mode_e          mode;
  logic              front_open, load, clr_q;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;
  logic              f_we_n;
  logic [DATA_W-1:0] words [DEPTH];

  assign mode       = wr_mode_e'(edge_mode);
  // both clock selects move together: clock or constant 1
  assign front_open = (mode == WR_EDGE) ? ~clk : 1'b1;
  assign load       = (mode == WR_EDGE) ?  clk : 1'b1;

  always_ff @(posedge clk) begin
    clr_q <= rst | clr;
  end

  lnr_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
    .open_i(front_open), .addr_i(wr_addr), .data_i(wr_data), .we_n_i(wr_en_n),
    .addr_o(f_addr), .data_o(f_data), .we_n_o(f_we_n)
  );

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    lnr_word #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX(w)) u_word (
      .clk(clk), .rst(rst), .edge_mode(edge_mode), .clr_i(clr_q), .load_i(load),
      .f_addr_i(f_addr), .f_we_n_i(f_we_n), .f_data_i(f_data), .q_o(words[w])
    );
  end

  lnr_read #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_read (
    .single_port(single_port), .rd_en(rd_en), .wr_addr(wr_addr),
    .rd_addr(rd_addr), .words_i(words), .rd_data(rd_data)
  );

  // R6: while the clear is active the output shows zero
  assert_clear_zero_R6: assert property (@(negedge clk) disable iff (rst)
    (clr_q && rd_en) |-> (rd_data == '0));

  // R7: disabled output stays at zero
  assert_oe_low_R7: assert property (@(negedge clk) disable iff (rst)
    !rd_en |-> (rd_data == '0));
endmodule

// File: tb/tb_latch_nibble_ram.sv
`timescale 1ns/1ps
module tb_latch_nibble_ram;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       edge_mode = 1'b1;
  logic       single_port = 1'b0;
  logic       clr = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic       wr_en_n = 1'b1;
  logic [4:0] rd_addr = '0;
  logic       rd_en = 1'b1;
  logic [3:0] rd_data;

  int tests = 0;
  int fails = 0;
  logic [3:0] model [32];

  always #4 clk = ~clk;

  latch_nibble_ram dut (
    .clk(clk), .rst(rst), .edge_mode(edge_mode), .single_port(single_port),
    .clr(clr), .wr_addr(wr_addr), .wr_data(wr_data), .wr_en_n(wr_en_n),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_data(rd_data)
  );

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [4:0] a, input logic [3:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(rd_data, exp, tag);
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 32; a++) rd(5'(a), model[a], tag);
  endtask

  task automatic edge_write(input logic [4:0] a, input logic [3:0] d);
    @(negedge clk); #1;
    wr_addr = a; wr_data = d; wr_en_n = 1'b0;
    @(posedge clk); #1;
    wr_en_n = 1'b1; wr_data = ~d; wr_addr = a + 5'd1;
    model[a] = d;
  endtask

  task automatic level_write(input logic [4:0] a, input logic [3:0] d);
    wr_addr = a; wr_data = d; #1;
    wr_en_n = 1'b0; #1;
    wr_en_n = 1'b1; #1;
    model[a] = d;
  endtask

  task automatic wipe();
    for (int a = 0; a < 32; a++) model[a] = '0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wipe();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #2;
    sweep("R9 reset state");

    // R1 R3: fill every word on clock edges
    for (int a = 0; a < 32; a++) edge_write(5'(a), 4'((a * 7 + 3) & 15));
    #2;
    sweep("R1 R3 edge fill");

    // R3: change while high is ignored; captured value is the one before the edge
    @(negedge clk); #1;
    wr_addr = 5'd5; wr_data = 4'hA; wr_en_n = 1'b0;
    #1 wr_data = 4'hB;
    @(posedge clk); #1;
    wr_data = 4'hC; wr_addr = 5'd6; #1;
    wr_en_n = 1'b1;
    model[5] = 4'hB;
    rd(5'd5, model[5], "R3 captured at edge");
    rd(5'd6, model[6], "R3 high phase ignored");

    // R3: strobe pulse confined to a low phase writes nothing
    @(negedge clk); #1;
    wr_addr = 5'd7; wr_data = ~model[7]; wr_en_n = 1'b0;
    #1 wr_data = 4'h0;
    #1 wr_en_n = 1'b1;
    @(posedge clk); #2;
    rd(5'd7, model[7], "R3 low phase pulse");

    // R4: strobe high across edges with varying inputs
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      wr_addr = 5'(i * 3); wr_data = 4'(i + 9); wr_en_n = 1'b1;
    end
    @(posedge clk); #2;
    sweep("R4 hold");

    // R2: address steps with no clock involvement
    @(posedge clk); #1;
    for (int a = 31; a >= 0; a--) begin
      rd_addr = 5'(a); #0.25;
      chk(rd_data, model[a], "R2 async read");
    end

    // R5: level mode write-through
    @(negedge clk); #1 edge_mode = 1'b0;
    wr_addr = 5'd9; rd_addr = 5'd9; wr_data = 4'h3; #1;
    wr_en_n = 1'b0; #1;
    chk(rd_data, 4'h3, "R5 write-through");
    wr_data = 4'hC; #1;
    chk(rd_data, 4'hC, "R5 follows data");
    wr_en_n = 1'b1; #1;
    wr_data = 4'h5; #1;
    chk(rd_data, 4'hC, "R5 keeps last");
    model[9] = 4'hC;
    sweep("R4 R5 others untouched");
    for (int a = 0; a < 32; a++) level_write(5'(a), 4'((a * 5 + 1) & 15));
    sweep("R1 R5 level fill");

    // R7: output enable low
    rd_en = 1'b0;
    for (int a = 0; a < 32; a++) rd(5'(a), 4'h0, "R7 oe low");
    rd_en = 1'b1;

    // R8: single port ignores rd_addr
    single_port = 1'b1;
    for (int a = 0; a < 32; a++) begin
      wr_addr = 5'(a); rd_addr = 5'(31 - a); #1;
      chk(rd_data, model[a], "R8 single port");
    end
    single_port = 1'b0;

    // R6: clear wins over same-edge write
    @(negedge clk); #1 edge_mode = 1'b1;
    @(negedge clk); #1;
    clr = 1'b1; wr_addr = 5'd2; wr_data = 4'h9; wr_en_n = 1'b0;
    @(posedge clk); #1;
    clr = 1'b0; wr_en_n = 1'b1;
    wipe();
    sweep("R6 clear");
    edge_write(5'd2, 4'h6);
    #2;
    rd(5'd2, 4'h6, "R6 write after clear");

    // R9: reset mid-run
    edge_write(5'd17, 4'hE);
    @(negedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    wipe();
    @(posedge clk); #2;
    sweep("R9 reset clears");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule